// File: doc/BRIEF.md
# Host Register Access Slave over I2C

This block lets an external system controller reach a 256-entry byte-wide host register space over a two-wire I2C bus. It responds only to its own 7-bit device address. In a write transfer the first byte after the address loads an internal register pointer. Every later byte is stored at the pointed location, and the pointer then steps forward. A read transfer returns bytes starting at the pointer, which also steps forward after each byte. The pointer is kept between transfers, so a read with no pointer phase continues from where the last access stopped. The usual way to read a chosen location is the combined format: a write that carries only the pointer byte, a repeated START, and then a read.

A few locations have fixed meaning. Two read-only identification bytes sit at the bottom of the space. Writing a 1 to bit 0 of a soft-reset location clears the command register and an interrupt-register window. When a write transfer that stored data ends, a one-cycle interrupt goes to the core if the enable bit in the command register is set. The core reaches the same array through a side port with a combinational read and a single-cycle write.

Top module: `i2c_hostreg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1011100 (0x5C). Any other address gets no acknowledge, and the slave neither acknowledges nor stores any byte until the next START.
- R2: SDA is sampled on SCL rising edges. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The slave only begins pulling SDA low while SCL is low.
- R3: In a matched write (address byte bit 0 = 0), the first byte after the address loads the register pointer.
- R4: Each further written byte is stored at the pointed register, and the pointer then increments by one.
- R5: In a matched read (address byte bit 0 = 1), bytes are returned MSB first starting at the current pointer, which increments after each byte. The pointer persists across transfers.
- R6: When the master does not acknowledge a read byte (SDA high on the 9th rising edge), the slave stops driving SDA until the next START.
- R7: Register 0x00 always reads 0x10 and register 0x01 always reads 0x20. Writes to them have no effect.
- R8: Writing a byte with bit 0 = 1 to register 0x10 produces a one-cycle soft-reset pulse. It clears register 0x13 and registers 0x40 through 0x4F and leaves all other registers unchanged. Register 0x10 reads 0, and a write with bit 0 = 0 does nothing.
- R9: A one-cycle interrupt is issued when a write transfer that stored at least one data byte ends (STOP or repeated START), if bit 0 of register 0x13 is 1 at that moment. Read transfers, and write transfers that only set the pointer, raise none.
- R10: The pointer wraps from 0xFF to 0x00.
- R11: The core side port reads any register combinationally and writes it in one cycle. Bus and side-port data are the same storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| core_we_i | input | 1 | Side-port write strobe |
| core_addr_i | input | 8 | Side-port register address |
| core_wdata_i | input | 8 | Side-port write data |
| core_rdata_o | output | 8 | Side-port read data |
| irq_o | output | 1 | Write-notification pulse to the core |
| soft_rst_o | output | 1 | Soft-reset pulse |

## Verification
The hardest state to reach is the pointer wrap, because it interacts with the read-only identification bytes. A burst write must start at 0xFE and run past 0xFF, so that its third byte lands on a protected location. A later bare read, with no pointer phase, must then show that the pointer kept moving to 0x01. The bench builds this sequence directly with a bit-level open-drain master model. It also sweeps all 128 device addresses and follows a master NACK with an extra clock, so that a released line can be observed.

// File: rtl/i2c_hr_pkg.sv
package i2c_hr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_PEND,
    ST_SACK,
    ST_TX,
    ST_MACK,
    ST_RD_NEXT
  } eng_state_t;

  typedef enum logic [1:0] {
    BY_DEV,
    BY_PTR,
    BY_DATA
  } rx_kind_t;

endpackage

// File: rtl/i2c_hr_bus_sync.sv
module i2c_hr_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic [SYNC_STAGES-1:0] scl_pipe_n, sda_pipe_n;
  logic scl_q, sda_q;

  always_comb begin
    scl_pipe_n = {scl_pipe[SYNC_STAGES-2:0], scl_i};
    sda_pipe_n = {sda_pipe[SYNC_STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= scl_pipe_n;
      sda_pipe <= sda_pipe_n;
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assert_start_stop_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

endmodule

// File: rtl/i2c_hr_engine.sv
module i2c_hr_engine
  import i2c_hr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5C,
  parameter int         AW       = 8,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe,
  output logic          xact_end
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] ALL_BITS = CW'(DW);

  eng_state_t    state, state_n;
  rx_kind_t      kind, kind_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [DW-1:0] sh, sh_n;
  logic [AW-1:0] ptr_n, wr_addr_n;
  logic [DW-1:0] wr_data_n;
  logic          rd_mode, rd_mode_n;
  logic          oe_n, wany, wany_n, wr_en_n, xend_n;
  logic [DW-1:0] rx_byte;

  assign rx_byte = {sh[DW-2:0], sda_s};

  always_comb begin
    state_n   = state;
    kind_n    = kind;
    cnt_n     = cnt;
    sh_n      = sh;
    ptr_n     = ptr;
    rd_mode_n = rd_mode;
    oe_n      = sda_oe;
    wany_n    = wany;
    wr_en_n   = 1'b0;
    wr_addr_n = wr_addr;
    wr_data_n = wr_data;
    xend_n    = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      xend_n  = wany;
      wany_n  = 1'b0;
    end else if (start_det) begin
      state_n = ST_RX;
      kind_n  = BY_DEV;
      cnt_n   = '0;
      oe_n    = 1'b0;
      xend_n  = wany;
      wany_n  = 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          sh_n  = rx_byte;
          cnt_n = cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            state_n = ST_ACK_PEND;
            unique case (kind)
              BY_DEV: begin
                if (rx_byte[DW-1:1] == DEV_ADDR) begin
                  rd_mode_n = rx_byte[0];
                  kind_n    = BY_PTR;
                end else begin
                  state_n = ST_IDLE;
                end
              end
              BY_PTR: begin
                ptr_n  = rx_byte[AW-1:0];
                kind_n = BY_DATA;
              end
              default: begin
                wr_en_n   = 1'b1;
                wr_addr_n = ptr;
                wr_data_n = rx_byte;
                ptr_n     = ptr + 1'b1;
                wany_n    = 1'b1;
              end
            endcase
          end
        end
        ST_ACK_PEND: if (scl_fall) begin
          oe_n    = 1'b1;
          state_n = ST_SACK;
        end
        ST_SACK, ST_RD_NEXT: if (scl_fall) begin
          cnt_n = '0;
          if (rd_mode) begin
            sh_n    = rd_data;
            oe_n    = ~rd_data[DW-1];
            ptr_n   = ptr + 1'b1;
            state_n = ST_TX;
          end else begin
            oe_n    = 1'b0;
            state_n = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == ALL_BITS) begin
              oe_n    = 1'b0;
              state_n = ST_MACK;
            end else begin
              sh_n = {sh[DW-2:0], 1'b0};
              oe_n = ~sh[DW-2];
            end
          end
        end
        ST_MACK: if (scl_rise) begin
          state_n = sda_s ? ST_IDLE : ST_RD_NEXT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= BY_DEV;
      cnt      <= '0;
      sh       <= '0;
      ptr      <= '0;
      rd_mode  <= 1'b0;
      sda_oe   <= 1'b0;
      wany     <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      xact_end <= 1'b0;
    end else begin
      state    <= state_n;
      kind     <= kind_n;
      cnt      <= cnt_n;
      sh       <= sh_n;
      ptr      <= ptr_n;
      rd_mode  <= rd_mode_n;
      sda_oe   <= oe_n;
      wany     <= wany_n;
      wr_en    <= wr_en_n;
      wr_addr  <= wr_addr_n;
      wr_data  <= wr_data_n;
      xact_end <= xend_n;
    end
  end

  assert_sda_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_wr_only_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_mode);

  assert_mack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK) |-> !sda_oe);

  assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '1) |-> (ptr == '0));

endmodule

// File: rtl/i2c_hr_regfile.sv
module i2c_hr_regfile #(
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter logic [DW-1:0] VERSION_VAL = 8'h10,
  parameter logic [DW-1:0] ID_VAL      = 8'h20,
  parameter int          SRST_ADDR   = 'h10,
  parameter int          CMD_ADDR    = 'h13,
  parameter int          INT_LO      = 'h40,
  parameter int          INT_HI      = 'h4F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  input  logic          xact_end,
  output logic          irq_o,
  output logic          soft_rst_o
);

  localparam int DEPTH = 1 << AW;
  localparam int VER_ADDR = 0;
  localparam int ID_ADDR  = 1;

  logic [DW-1:0] mem   [DEPTH];
  logic [DW-1:0] mem_n [DEPTH];
  logic          wr_any, srst_req;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          irq_n;

  function automatic logic storable(input int i);
    return (i != VER_ADDR) && (i != ID_ADDR) && (i != SRST_ADDR);
  endfunction

  function automatic logic clearable(input int i);
    return (i == CMD_ADDR) || ((i >= INT_LO) && (i <= INT_HI));
  endfunction

  function automatic logic [DW-1:0] read_at(input logic [AW-1:0] a);
    if (a == AW'(VER_ADDR))       return VERSION_VAL;
    else if (a == AW'(ID_ADDR))   return ID_VAL;
    else if (a == AW'(SRST_ADDR)) return '0;
    else                          return mem[a];
  endfunction

  assign wr_any   = bus_we | core_we;
  assign wr_addr  = bus_we ? bus_waddr : core_addr;
  assign wr_data  = bus_we ? bus_wdata : core_wdata;
  assign srst_req = wr_any && (wr_addr == AW'(SRST_ADDR)) && wr_data[0];
  assign irq_n    = xact_end & mem[CMD_ADDR][0];

  assign bus_rdata  = read_at(bus_raddr);
  assign core_rdata = read_at(core_addr);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_n[i] = mem[i];
      if (srst_req && clearable(i))
        mem_n[i] = '0;
      else if (wr_any && (wr_addr == AW'(i)) && storable(i))
        mem_n[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      irq_o      <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
      irq_o      <= irq_n;
      soft_rst_o <= srst_req;
    end
  end

  assert_srst_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> (soft_rst_o && mem[CMD_ADDR] == '0 && mem[INT_LO] == '0));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(xact_end));

endmodule

// File: rtl/i2c_hostreg_slave.sv
module i2c_hostreg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h5C,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] VERSION_VAL = 8'h10,
  parameter logic [7:0] ID_VAL      = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       core_we_i,
  input  logic [7:0] core_addr_i,
  input  logic [7:0] core_wdata_i,
  output logic [7:0] core_rdata_o,
  output logic       irq_o,
  output logic       soft_rst_o
);

  localparam int AW = 8;
  localparam int DW = 8;

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] ptr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, xact_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2c_hr_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_hr_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) eng_i (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe_o), .xact_end(xact_end)
  );

  i2c_hr_regfile #(.AW(AW), .DW(DW), .VERSION_VAL(VERSION_VAL), .ID_VAL(ID_VAL)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .bus_we(wr_en), .bus_waddr(wr_addr),
    .bus_wdata(wr_data), .bus_raddr(ptr), .bus_rdata(rd_data),
    .core_we(core_we_i), .core_addr(core_addr_i), .core_wdata(core_wdata_i),
    .core_rdata(core_rdata_o), .xact_end(xact_end), .irq_o(irq_o),
    .soft_rst_o(soft_rst_o)
  );

endmodule

// File: tb/i2c_hostreg_slave_tb_top.sv
module i2c_hostreg_slave_tb_top;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic core_we = 1'b0;
  logic [7:0] core_addr = 8'h00, core_wdata = 8'h00, core_rdata;
  logic irq, srst;
  wire  sda_line = m_sda & ~sda_oe;

  int total = 0, bad = 0, irq_cnt = 0, srst_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_hostreg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .core_we_i(core_we), .core_addr_i(core_addr), .core_wdata_i(core_wdata),
    .core_rdata_o(core_rdata), .irq_o(irq), .soft_rst_o(srst)
  );

  always @(negedge clk) begin
    if (irq)  irq_cnt++;
    if (srst) srst_cnt++;
  end

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); m_scl = 1'b1; wq(); v = {v[6:0], sda_line}; wq(); m_scl = 1'b0;
    end
    wq(); m_sda = nack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq(); m_sda = 1'b1;
  endtask

  task automatic core_rd(input logic [7:0] a, output logic [7:0] v);
    core_addr = a; #1; v = core_rdata;
  endtask

  task automatic core_wr(input logic [7:0] a, input logic [7:0] d);
    core_we = 1'b1; core_addr = a; core_wdata = d;
    @(negedge clk); core_we = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start(); send_byte(8'hB8, a); send_byte(p, a); bus_stop();
  endtask

  task automatic write1(input logic [7:0] p, input logic [7:0] d);
    logic a;
    bus_start(); send_byte(8'hB8, a); send_byte(p, a); send_byte(d, a); bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    chk("reset sda_oe R2", int'(sda_oe), 0);
    chk("reset irq R9", int'(irq), 0);
    core_rd(8'h00, v); chk("version R7", v, 8'h10);
    core_rd(8'h01, v); chk("id R7", v, 8'h20);

    for (int ad = 0; ad < 128; ad++) begin
      bus_start(); send_byte({7'(ad), 1'b0}, a); bus_stop();
      chk("address sweep R1", int'(a), int'(ad == 'h5C));
    end
    bus_start(); send_byte(8'hB9, a); chk("read address ack R1", int'(a), 1);
    recv_byte(1'b1, v); bus_stop();

    bus_start(); send_byte(8'hB8, a); send_byte(8'h20, a);
    chk("pointer byte ack R3", int'(a), 1);
    for (int k = 0; k < 16; k++) begin
      send_byte(pat(k), a); chk("data ack R4", int'(a), 1);
    end
    bus_stop();
    core_rd(8'h20, v); chk("first write at pointer R3", v, pat(0));
    for (int k = 1; k < 16; k++) begin
      core_rd(8'(8'h20 + k), v); chk("burst write R4", v, pat(k));
    end

    bus_start(); send_byte(8'hBA, a); chk("mismatch nack R1", int'(a), 0);
    send_byte(8'h20, a); chk("ignored pointer R1", int'(a), 0);
    send_byte(8'h55, a); chk("ignored data R1", int'(a), 0);
    bus_stop();
    core_rd(8'h20, v); chk("mismatch no store R1", v, pat(0));

    bus_start(); send_byte(8'hB8, a); send_byte(8'h22, a);
    bus_start(); send_byte(8'hB9, a);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k == 3, v); chk("combined burst read R5", v, pat(2 + k));
    end
    wq(); m_scl = 1'b1; wq(); chk("released after nack R6", int'(sda_line), 1);
    wq(); m_scl = 1'b0; wq();
    bus_stop();
    bus_start(); send_byte(8'hB9, a);
    recv_byte(1'b0, v); chk("bare read continues R5", v, pat(6));
    recv_byte(1'b1, v); chk("bare read increments R5", v, pat(7));
    bus_stop();

    bus_start(); send_byte(8'hB8, a); send_byte(8'hFE, a);
    send_byte(8'hA1, a); send_byte(8'hB2, a); send_byte(8'hC3, a); bus_stop();
    core_rd(8'hFE, v); chk("write at 0xFE R10", v, 8'hA1);
    core_rd(8'hFF, v); chk("write at 0xFF R10", v, 8'hB2);
    core_rd(8'h00, v); chk("read-only after wrap R7", v, 8'h10);
    bus_start(); send_byte(8'hB9, a); recv_byte(1'b1, v); bus_stop();
    chk("pointer wrapped to 0x01 R10", v, 8'h20);
    write1(8'h01, 8'h99);
    core_rd(8'h01, v); chk("id write ignored R7", v, 8'h20);

    core_wr(8'h30, 8'h5A);
    set_ptr(8'h30);
    bus_start(); send_byte(8'hB9, a); recv_byte(1'b1, v); bus_stop();
    chk("side write seen on bus R11", v, 8'h5A);
    write1(8'h31, 8'h6B);
    core_rd(8'h31, v); chk("bus write seen on side R11", v, 8'h6B);

    chk("no irq while disabled R9", irq_cnt, 0);
    write1(8'h13, 8'h01);
    chk("irq after enable write R9", irq_cnt, 1);
    write1(8'h60, 8'h77);
    chk("irq after data write R9", irq_cnt, 2);
    set_ptr(8'h60);
    chk("no irq for pointer-only R9", irq_cnt, 2);
    bus_start(); send_byte(8'hB9, a); recv_byte(1'b1, v); bus_stop();
    chk("no irq for read R9", irq_cnt, 2);

    core_wr(8'h40, 8'hAA); core_wr(8'h4F, 8'hBB); core_wr(8'h50, 8'hCC);
    write1(8'h10, 8'h02);
    chk("bit0 clear no soft reset R8", srst_cnt, 0);
    core_rd(8'h13, v); chk("cmd kept R8", v, 8'h01);
    chk("irq on that write R9", irq_cnt, 3);
    write1(8'h10, 8'h01);
    chk("soft reset pulse R8", srst_cnt, 1);
    core_rd(8'h13, v); chk("cmd cleared R8", v, 8'h00);
    core_rd(8'h40, v); chk("int low cleared R8", v, 8'h00);
    core_rd(8'h4F, v); chk("int high cleared R8", v, 8'h00);
    core_rd(8'h50, v); chk("outside kept R8", v, 8'hCC);
    core_rd(8'h20, v); chk("data kept R8", v, pat(0));
    core_rd(8'h10, v); chk("soft reset reads 0 R8", v, 8'h00);
    chk("no irq after clear R9", irq_cnt, 3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule